// File: doc/BRIEF.md
# Multi-Buffer DMA Address Sequencer

This block generates the source and destination addresses for one DMA channel whose transfer is split into several buffers. Software writes the channel setup through a small register port and then pulses `start`. The sequencer then presents an address pair for each data beat. It moves both addresses forward each time the data mover reports a completed beat. At each buffer boundary it decides where the next buffer begins.

The source side and the destination side each choose their own way of reaching the next buffer. In contiguous mode the side keeps counting from where the previous buffer stopped. In reload mode the side returns to the start address captured when the channel was started. In chained mode a four-word list item is read from memory through a simple request/response port, and that item supplies the next buffer. When either side is chained, the buffer length and the end of the transfer come from the list items. When neither side is chained, a programmed buffer count decides how many buffers are run.

Top module: `mbuf_addr_seq`

## Requirements
- R1: After reset, `addr_valid`, `buf_start`, `xfer_done` and `mem_req` are low.
- R2: Setup registers are selected by `cfg_sel`:
  - 0 is the source start address.
  - 1 is the destination start address.
  - 2 is the buffer length in beats.
  - 3 is the first list item pointer.
  - 4 is the mode word: bits [1:0] source mode, bits [3:2] destination mode, bits [5:4] beat size code, bits [15:8] buffer count.

  Writes made while a transfer is running are ignored, and so is a `start` pulse made while a transfer is running.
- R3: If either side's mode is chained (code 2), a list item is read before every buffer, including the first:
  - It is four word reads, one at a time, at pointer +0, +4, +8 and +12.
  - The words are: source address, destination address, length in beats (low bits), next pointer.
  - `addr_valid` stays low while the item is being read, and `beat_done` has no effect during that time.
- R4: A side in reload mode (code 1) returns to the start address captured at `start` when each buffer ends.
- R5: A side in contiguous mode (code 0) begins each new buffer one beat size past the last address of the previous buffer.
- R6: Each side follows its own mode. A side that is not chained ignores the address word of a list item, and its first buffer begins at its programmed start address. A chained side takes its address from the list item.
- R7: Each address advances by the beat size after every beat accepted with `beat_done` high while `addr_valid` is high. Size code 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. The addresses hold while `beat_done` is low.
- R8: `buf_start` is high for exactly the first cycle in which a new buffer's addresses are valid.
- R9: A list item whose next pointer is zero makes its buffer the last one. `xfer_done` is high for one cycle, the cycle after that buffer's final beat, and `addr_valid` is low from then on.
- R10: With no chained side, the transfer runs exactly the programmed buffer count of buffers, each of the programmed length, and then pulses `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_sel | input | 3 | Setup register select |
| cfg_wdata | input | AW | Setup write data |
| start | input | 1 | Start pulse for the channel |
| beat_done | input | 1 | Data mover completed the current beat |
| mem_req | output | 1 | List item word read request |
| mem_addr | output | AW | List item word address |
| mem_rdata | input | AW | Read data |
| mem_rvalid | input | 1 | Read data valid |
| src_addr | output | AW | Current source address |
| dst_addr | output | AW | Current destination address |
| addr_valid | output | 1 | Addresses are valid for a beat |
| buf_start | output | 1 | First cycle of a new buffer |
| xfer_done | output | 1 | Transfer finished |

## Verification
The hardest situations to reach are the buffer boundaries in a mixed-mode transfer, where one side is chained and the other side reloads or continues on its own. Reaching them needs a sequence of list items placed in a memory model, including one whose next pointer is zero. The bench answers every read request from that model one cycle after it is made. It holds `beat_done` high throughout, so the ignored beats during item reads and the boundary beats both occur. Each address presented is compared against a list built from the requirements, and the read addresses are compared against the expected word order.

// File: rtl/mbuf_pkg.sv
package mbuf_pkg;

  typedef enum logic [1:0] {
    ADV_CONT   = 2'd0,
    ADV_RELOAD = 2'd1,
    ADV_CHAIN  = 2'd2
  } adv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;

  // Bytes moved per beat for a size code.
  function automatic logic [2:0] beat_bytes(input logic [1:0] code);
    case (code)
      2'd0:    beat_bytes = 3'd1;
      2'd1:    beat_bytes = 3'd2;
      default: beat_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/mbuf_side.sv
module mbuf_side
  import mbuf_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_load,
  input  logic [AW-1:0] init_addr,
  input  logic [1:0]    mode,
  input  logic          step,
  input  logic          buf_end,
  input  logic [2:0]    step_bytes,
  input  logic          desc_load,
  input  logic [AW-1:0] desc_word,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] base_q, addr_q, addr_d;
  logic          addr_en, is_chain, is_reload;

  assign is_chain  = (mode == ADV_CHAIN);
  assign is_reload = (mode == ADV_RELOAD);
  assign addr_en   = init_load | (desc_load & is_chain) | step;

  always_comb begin
    addr_d = addr_q;
    if (init_load)
      addr_d = init_addr;
    else if (desc_load && is_chain)
      addr_d = desc_word;
    else if (step) begin
      if (buf_end && is_reload)
        addr_d = base_q;
      else
        addr_d = addr_q + AW'(step_bytes);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      addr_q <= '0;
    end else begin
      if (init_load) base_q <= init_addr;
      if (addr_en)   addr_q <= addr_d;
    end
  end

  assign addr = addr_q;

  // R7
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !buf_end && !init_load && !desc_load)
      |=> (addr == $past(addr) + AW'($past(step_bytes))));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !init_load && !desc_load) |=> $stable(addr));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && buf_end && is_reload && !init_load) |=> (addr == base_q));

  // R6
  ignore_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_load && !is_chain && !step && !init_load) |=> $stable(addr));

endmodule

// File: rtl/mbuf_ctrl.sv
module mbuf_ctrl
  import mbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    dst_mode,
  input  logic [AW-1:0] cfg_dscr,
  input  logic [LW-1:0] cfg_len,
  input  logic [CW-1:0] cfg_bufs,
  input  logic          beat_done,
  input  logic          mem_rvalid,
  input  logic [AW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          init_load,
  output logic          step,
  output logic          buf_end,
  output logic          desc_load_src,
  output logic          desc_load_dst,
  output logic          busy,
  output logic          addr_valid,
  output logic          buf_start,
  output logic          xfer_done
);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [1:0]    widx_q, widx_d;
  logic [LW-1:0] remain_q, remain_d, len_base_q, len_base_d;
  logic [CW-1:0] bufs_q, bufs_d;
  logic          bs_q, bs_d, done_q, done_d;
  logic          chained, desc_hit, last_buf;

  assign chained   = (src_mode == ADV_CHAIN) || (dst_mode == ADV_CHAIN);
  assign init_load = (state_q == ST_IDLE) && start;
  assign step      = (state_q == ST_RUN) && beat_done;
  assign buf_end   = step && (remain_q == LW'(1));
  assign desc_hit  = (state_q == ST_WAIT) && mem_rvalid;
  assign desc_load_src = desc_hit && (widx_q == 2'd0);
  assign desc_load_dst = desc_hit && (widx_q == 2'd1);
  assign last_buf  = chained ? (ptr_q == '0) : (bufs_q == CW'(1));
  assign mem_req   = (state_q == ST_FETCH);
  assign mem_addr  = ptr_q + AW'({widx_q, 2'b00});
  assign busy      = (state_q != ST_IDLE);
  assign addr_valid = (state_q == ST_RUN);
  assign buf_start = bs_q;
  assign xfer_done = done_q;

  always_comb begin
    state_d    = state_q;
    ptr_d      = ptr_q;
    widx_d     = widx_q;
    remain_d   = remain_q;
    len_base_d = len_base_q;
    bufs_d     = bufs_q;
    bs_d       = 1'b0;
    done_d     = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        len_base_d = cfg_len;
        bufs_d     = cfg_bufs;
        if (chained) begin
          ptr_d   = cfg_dscr;
          widx_d  = 2'd0;
          state_d = ST_FETCH;
        end else begin
          remain_d = cfg_len;
          bs_d     = 1'b1;
          state_d  = ST_RUN;
        end
      end
      ST_FETCH: state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid) begin
        if (widx_q == 2'd2) remain_d = mem_rdata[LW-1:0];
        if (widx_q == 2'd3) begin
          ptr_d   = mem_rdata;
          bs_d    = 1'b1;
          state_d = ST_RUN;
        end else begin
          widx_d  = widx_q + 2'd1;
          state_d = ST_FETCH;
        end
      end
      ST_RUN: if (step) begin
        remain_d = remain_q - LW'(1);
        if (buf_end) begin
          if (last_buf) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else if (chained) begin
            widx_d  = 2'd0;
            state_d = ST_FETCH;
          end else begin
            remain_d = len_base_q;
            bufs_d   = bufs_q - CW'(1);
            bs_d     = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      ptr_q      <= '0;
      widx_q     <= '0;
      remain_q   <= '0;
      len_base_q <= '0;
      bufs_q     <= '0;
      bs_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      ptr_q      <= ptr_d;
      widx_q     <= widx_d;
      remain_q   <= remain_d;
      len_base_q <= len_base_d;
      bufs_q     <= bufs_d;
      bs_q       <= bs_d;
      done_q     <= done_d;
    end
  end

  // R3
  fetch_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !addr_valid);

  // R3
  word_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_hit && widx_q != 2'd3) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(4)));

  // R8
  bstart_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_start |-> addr_valid);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!addr_valid && !mem_req && !buf_start));

endmodule

// File: rtl/mbuf_addr_seq.sv
module mbuf_addr_seq
  import mbuf_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          start,
  input  logic          beat_done,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_rvalid,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          addr_valid,
  output logic          buf_start,
  output logic          xfer_done
);

  localparam int MW = 8 + CW;

  logic [AW-1:0] cfg_src_q, cfg_dst_q, cfg_dscr_q;
  logic [LW-1:0] cfg_len_q;
  logic [MW-1:0] cfg_mode_q;
  logic          busy, wr_en;
  logic          init_load, step, buf_end, dl_src, dl_dst;
  logic [2:0]    step_bytes;

  assign wr_en = cfg_we && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_src_q  <= '0;
      cfg_dst_q  <= '0;
      cfg_len_q  <= '0;
      cfg_dscr_q <= '0;
      cfg_mode_q <= '0;
    end else if (wr_en) begin
      case (cfg_sel)
        3'd0: cfg_src_q  <= cfg_wdata;
        3'd1: cfg_dst_q  <= cfg_wdata;
        3'd2: cfg_len_q  <= cfg_wdata[LW-1:0];
        3'd3: cfg_dscr_q <= cfg_wdata;
        3'd4: cfg_mode_q <= cfg_wdata[MW-1:0];
        default: ;
      endcase
    end
  end

  assign step_bytes = beat_bytes(cfg_mode_q[5:4]);

  mbuf_ctrl #(.AW(AW), .LW(LW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .src_mode(cfg_mode_q[1:0]), .dst_mode(cfg_mode_q[3:2]),
    .cfg_dscr(cfg_dscr_q), .cfg_len(cfg_len_q), .cfg_bufs(cfg_mode_q[MW-1:8]),
    .beat_done(beat_done), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .init_load(init_load),
    .step(step), .buf_end(buf_end), .desc_load_src(dl_src),
    .desc_load_dst(dl_dst), .busy(busy), .addr_valid(addr_valid),
    .buf_start(buf_start), .xfer_done(xfer_done)
  );

  mbuf_side #(.AW(AW)) u_src (
    .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_addr(cfg_src_q),
    .mode(cfg_mode_q[1:0]), .step(step), .buf_end(buf_end),
    .step_bytes(step_bytes), .desc_load(dl_src), .desc_word(mem_rdata),
    .addr(src_addr)
  );

  mbuf_side #(.AW(AW)) u_dst (
    .clk(clk), .rst_n(rst_n), .init_load(init_load), .init_addr(cfg_dst_q),
    .mode(cfg_mode_q[3:2]), .step(step), .buf_end(buf_end),
    .step_bytes(step_bytes), .desc_load(dl_dst), .desc_word(mem_rdata),
    .addr(dst_addr)
  );

  // R2
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && busy) |=> $stable(cfg_src_q) && $stable(cfg_mode_q));

endmodule

// File: tb/mbuf_addr_seq_bench.sv
module mbuf_addr_seq_bench;

  logic        clk, rst_n, cfg_we, start, beat_done, mem_req, mem_rvalid;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata, mem_addr, mem_rdata, src_addr, dst_addr;
  logic        addr_valid, buf_start, xfer_done;

  int n_chk = 0, n_fail = 0;
  logic [31:0] dmem [0:63];
  logic [31:0] req_log [0:31];
  int req_n;
  logic [31:0] e_src [0:15];
  logic [31:0] e_dst [0:15];
  bit          e_bs  [0:15];
  int          e_n;

  mbuf_addr_seq u_mbuf_addr_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .start(start), .beat_done(beat_done),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .src_addr(src_addr), .dst_addr(dst_addr),
    .addr_valid(addr_valid), .buf_start(buf_start), .xfer_done(xfer_done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Memory model: answers each request one cycle later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      req_n      <= 0;
    end else begin
      mem_rvalid <= mem_req;
      mem_rdata  <= dmem[mem_addr[7:2]];
      if (mem_req && req_n < 32) begin
        req_log[req_n] <= mem_addr;
        req_n <= req_n + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mw(input int sm, input int dm, input int sz, input int nb);
    return 32'((nb << 8) | (sz << 4) | (dm << 2) | sm);
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic kick();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Consume beats with beat_done high and compare against e_* lists.
  task automatic run_xfer(input string tag);
    int idx = 0;
    beat_done = 1'b1;
    for (int c = 0; c < 400 && idx < e_n; c++) begin
      if (addr_valid) begin
        chk(src_addr == e_src[idx], {tag, " src"}, src_addr, e_src[idx]);
        chk(dst_addr == e_dst[idx], {tag, " dst"}, dst_addr, e_dst[idx]);
        chk(buf_start == e_bs[idx], {tag, " R8 buf_start"}, 32'(buf_start), 32'(e_bs[idx]));
        idx++;
      end
      @(negedge clk);
    end
    chk(idx == e_n, {tag, " beat count"}, idx, e_n);
    chk(xfer_done && !addr_valid, {tag, " R9 done pulse"}, 32'(xfer_done), 1);
    beat_done = 1'b0;
    @(negedge clk);
    chk(!xfer_done, {tag, " R9 done one cycle"}, 32'(xfer_done), 0);
  endtask

  task automatic t_reset();
    chk(!addr_valid && !buf_start && !xfer_done && !mem_req, "R1 reset outputs",
        {addr_valid, buf_start, xfer_done, mem_req}, 0);
  endtask

  task automatic t_contig();  // R5 R10 R7: size 4, 3 beats, 2 buffers
    wr(0, 32'h1000); wr(1, 32'h2000); wr(2, 3); wr(4, mw(0, 0, 2, 2));
    e_n = 6;
    for (int i = 0; i < 6; i++) begin
      e_src[i] = 32'h1000 + 4 * i; e_dst[i] = 32'h2000 + 4 * i; e_bs[i] = (i % 3 == 0);
    end
    kick();
    run_xfer("R5 R10 contiguous");
  endtask

  task automatic t_reload();  // R4 R10: size 2, 2 beats, 3 buffers
    wr(0, 32'h100); wr(1, 32'h300); wr(2, 2); wr(4, mw(1, 1, 1, 3));
    e_n = 6;
    for (int i = 0; i < 6; i++) begin
      e_src[i] = 32'h100 + 2 * (i % 2); e_dst[i] = 32'h300 + 2 * (i % 2); e_bs[i] = (i % 2 == 0);
    end
    kick();
    run_xfer("R4 reload");
  endtask

  task automatic t_mixed();  // R6: src reload, dst contiguous, size 1
    wr(0, 32'h40); wr(1, 32'h80); wr(2, 3); wr(4, mw(1, 0, 0, 2));
    e_n = 6;
    for (int i = 0; i < 6; i++) begin
      e_src[i] = 32'h40 + (i % 3); e_dst[i] = 32'h80 + i; e_bs[i] = (i % 3 == 0);
    end
    kick();
    run_xfer("R6 mixed");
  endtask

  task automatic t_chain_src();  // R3 R6 R9: src chained, dst contiguous
    int base;
    dmem[16] = 32'h5000; dmem[17] = 32'hDEAD0000; dmem[18] = 2; dmem[19] = 32'h80;
    dmem[32] = 32'h6000; dmem[33] = 32'hBEEF0000; dmem[34] = 1; dmem[35] = 0;
    wr(0, 32'h99990000); wr(1, 32'h3000); wr(3, 32'h40); wr(4, mw(2, 0, 2, 1));
    e_n = 3;
    e_src[0] = 32'h5000; e_src[1] = 32'h5004; e_src[2] = 32'h6000;
    e_dst[0] = 32'h3000; e_dst[1] = 32'h3004; e_dst[2] = 32'h3008;
    e_bs[0] = 1; e_bs[1] = 0; e_bs[2] = 1;
    base = req_n;
    kick();
    run_xfer("R3 R6 chain src");
    chk(req_n - base == 8, "R3 read count", req_n - base, 8);
    for (int i = 0; i < 4; i++) begin
      chk(req_log[base + i] == 32'h40 + 4 * i, "R3 item0 word order", req_log[base + i], 32'h40 + 4 * i);
      chk(req_log[base + 4 + i] == 32'h80 + 4 * i, "R3 item1 word order", req_log[base + 4 + i], 32'h80 + 4 * i);
    end
  endtask

  task automatic t_chain_dst();  // R4 R6 R9: src reload, dst chained, size 2
    dmem[48] = 32'hAAAA; dmem[49] = 32'h8000; dmem[50] = 1; dmem[51] = 32'hD0;
    dmem[52] = 32'hBBBB; dmem[53] = 32'h8100; dmem[54] = 2; dmem[55] = 0;
    wr(0, 32'h700); wr(3, 32'hC0); wr(4, mw(1, 2, 1, 1));
    e_n = 3;
    e_src[0] = 32'h700;  e_src[1] = 32'h700;  e_src[2] = 32'h702;
    e_dst[0] = 32'h8000; e_dst[1] = 32'h8100; e_dst[2] = 32'h8102;
    e_bs[0] = 1; e_bs[1] = 1; e_bs[2] = 0;
    kick();
    run_xfer("R6 R9 chain dst");
  endtask

  task automatic t_stall_lock();  // R7 hold, R2 writes and start ignored when busy
    wr(0, 32'h10); wr(1, 32'h20); wr(2, 4); wr(4, mw(0, 0, 0, 1));
    kick();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(src_addr == 32'h10 && addr_valid, "R7 hold without beat", src_addr, 32'h10);
    end
    wr(0, 32'h999);
    start = 1'b1; @(negedge clk); start = 1'b0;
    e_n = 4;
    for (int i = 0; i < 4; i++) begin
      e_src[i] = 32'h10 + i; e_dst[i] = 32'h20 + i; e_bs[i] = 0;
    end
    run_xfer("R2 R7 busy");
    e_bs[0] = 1;
    kick();
    run_xfer("R2 setup kept");
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    start = 1'b0; beat_done = 1'b0;
    for (int i = 0; i < 64; i++) dmem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_contig();
    t_reload();
    t_mixed();
    t_chain_src();
    t_chain_dst();
    t_stall_lock();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule